// File: doc/BRIEF.md
# PHY Management Bus Master

This block drives the two-wire management bus of an Ethernet PHY (Clause 22 framing). Software programs a clock divider once and then writes a single 32-bit command word. That word carries the start code, the opcode, the PHY and register addresses, the turnaround bits and the write data. A command write starts a frame. The block sends 32 preamble ones and then the command word, most significant bit first. It produces the management clock and controls the data pin through separate input, output and output-enable signals.

During a read, the block releases the data pin for the turnaround and data phases and samples the 16 bits the PHY returns. It places them in the low half of the data register. At the end of every frame it sets a completion event, which software clears by writing 1. A status bit shows whether a frame is in flight. Commands that arrive while a frame is in flight are dropped. Commands that arrive while the divider is zero are also dropped.

Top module: `mdio_master`

## Requirements
- R1: A command write to register address 0, accepted while idle with a nonzero divider, produces exactly 64 MDC rising edges. On those edges MDIO carries 32 ones and then the 32 command bits, most significant bit first.
- R2: The command word is laid out as follows: bits [31:30] start code, bits [29:28] opcode (2'b10 read, any other value is handled as a write), bits [27:23] PHY address, bits [22:18] register address, bits [17:16] turnaround, bits [15:0] write data.
- R3: In a write frame the output enable is high for all 64 bits. In a read frame it is high for the first 46 bits and low for the last 18 (turnaround and data). Output enable changes only when MDC falls.
- R4: The divider field is bits [6:1] of register address 2 and reads back at the same position. With field value D, MDC has a period of 2·D system clocks. MDC stays low whenever no frame is in flight.
- R5: After a read frame, bits [15:0] of register address 0 hold the 16 MDIO values sampled at MDC rising edges 49 to 64, with the first sampled bit as the MSB, and bits [31:16] read zero. After a write frame, bits [15:0] hold the write data.
- R6: Bit 0 of register address 1 is set when a frame ends. Writing 1 to it clears it. Writing 0 leaves it unchanged.
- R7: Bit 0 of register address 3 reads 1 from the cycle after a command is accepted until the frame ends. A command written during that time is ignored and does not alter the frame in flight.
- R8: While the divider field is zero, a command write starts no frame. No MDC edge appears, busy stays 0 and no event is raised.
- R9: MDIO output data changes only on a falling MDC edge while a frame is in flight.
- R10: After reset, MDC, output enable and every readable register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command/data, 1 event, 2 divider, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data pin input from the pad |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |

## Verification
The embedded assertions check the edge discipline on every cycle. Data and output enable may move only on a falling MDC edge. MDC must be low while idle. No command may be accepted while busy. A zero divider must never let a frame begin. The fall of busy must always leave the event bit set. Only the bench scenarios can show the frame contents, the read/write output-enable profiles, the exact MDC period for each divider value, the bit order of captured read data, and the write-1-to-clear behaviour. The bench covers these with a sweep over divider values and command patterns, against a bench-side PHY model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int CMD_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DATA_BITS  = 16;
    localparam int TA_BITS    = 2;
    localparam int DRIVE_BITS = FRAME_BITS - DATA_BITS - TA_BITS;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef struct packed {
        logic [1:0]           st;
        logic [1:0]           opc;
        logic [4:0]           phy;
        logic [4:0]           regn;
        logic [TA_BITS-1:0]   ta;
        logic [DATA_BITS-1:0] wdata;
    } mdio_cmd_t;

    typedef enum logic [1:0] {
        RA_CMD   = 2'd0,
        RA_EVENT = 2'd1,
        RA_DIV   = 2'd2,
        RA_STAT  = 2'd3
    } reg_sel_e;

    function automatic logic cmd_is_read(input mdio_cmd_t c);
        return c.opc == OPC_READ;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        return {{PRE_BITS{1'b1}}, c};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    input  logic             run,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    assign tick   = run && ({1'b0, cnt_q} + 1'b1 >= {1'b0, div_q});
    assign rise_p = tick && !mdc_q;
    assign fall_p = tick && mdc_q;
    assign mdc    = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            if (load) begin
                div_q <= div;
            end
            if (!run) begin
                cnt_q <= '0;
                mdc_q <= 1'b0;
            end else if (tick) begin
                cnt_q <= '0;
                mdc_q <= ~mdc_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r4_no_tick_on_zero: assert property (@(posedge clk) disable iff (rst)
        (run && div_q == '0) |-> !tick);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mdio_cmd_t            cmd,
    input  logic                 mdc,
    input  logic                 rise_p,
    input  logic                 fall_p,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic                 mdo,
    output logic                 oe,
    output logic [DATA_BITS-1:0] result
);
    logic [FRAME_BITS-1:0] shift_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    logic                  rd_q;
    logic [DATA_BITS-1:0]  cap_q;
    logic [DATA_BITS-1:0]  wdat_q;
    logic                  last_bit;
    logic                  in_data;

    assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign in_data  = (idx_q >= IDX_W'(FRAME_BITS - DATA_BITS));
    assign done     = busy_q && fall_p && last_bit;
    assign busy     = busy_q;
    assign mdo      = busy_q & shift_q[FRAME_BITS-1];
    assign oe       = busy_q && (!rd_q || (idx_q < IDX_W'(DRIVE_BITS)));
    assign result   = rd_q ? cap_q : wdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            idx_q   <= '0;
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
            wdat_q  <= '0;
        end else if (start && !busy_q) begin
            shift_q <= build_frame(cmd);
            idx_q   <= '0;
            busy_q  <= 1'b1;
            rd_q    <= cmd_is_read(cmd);
            wdat_q  <= cmd.wdata;
            cap_q   <= '0;
        end else if (busy_q) begin
            if (rise_p && rd_q && in_data) begin
                cap_q <= {cap_q[DATA_BITS-2:0], mdio_i};
            end
            if (fall_p) begin
                if (last_bit) begin
                    busy_q <= 1'b0;
                end else begin
                    shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
                    idx_q   <= idx_q + 1'b1;
                end
            end
        end
    end

    a_r9_mdo_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdo)) |-> $fell(mdc));

    a_r3_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $fell(oe)) |-> $fell(mdc));

    a_r7_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 busy,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] result,
    output logic                 start,
    output mdio_cmd_t            cmd,
    output logic [DIV_W-1:0]     div
);
    logic [DIV_W-1:0]     div_q;
    logic                 evt_q;
    logic [DATA_BITS-1:0] data_q;
    reg_sel_e             sel;

    assign sel   = reg_sel_e'(reg_addr);
    assign cmd   = mdio_cmd_t'(reg_wdata);
    assign div   = div_q;
    assign start = reg_we && (sel == RA_CMD) && !busy && (div_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            evt_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (reg_we && sel == RA_DIV) begin
                div_q <= reg_wdata[DIV_W:1];
            end
            if (done) begin
                evt_q <= 1'b1;
            end else if (reg_we && sel == RA_EVENT && reg_wdata[0]) begin
                evt_q <= 1'b0;
            end
            if (done) begin
                data_q <= result;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RA_CMD:   reg_rdata[DATA_BITS-1:0] = data_q;
            RA_EVENT: reg_rdata[0]             = evt_q;
            RA_DIV:   reg_rdata[DIV_W:1]       = div_q;
            RA_STAT:  reg_rdata[0]             = busy;
            default:  reg_rdata                = '0;
        endcase
    end

    a_r6_event_on_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> evt_q);

    a_r8_no_frame_div0: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0 && !busy) |=> !busy);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic                 start;
    mdio_cmd_t            cmd;
    logic [DIV_W-1:0]     div;
    logic                 busy;
    logic                 done;
    logic [DATA_BITS-1:0] result;
    logic                 rise_p;
    logic                 fall_p;

    mdio_csr #(.DIV_W(DIV_W)) csr_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .start     (start),
        .cmd       (cmd),
        .div       (div)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) clk_i (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .div    (div),
        .run    (busy),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_engine eng_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmd    (cmd),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p),
        .mdio_i (mdio_i),
        .busy   (busy),
        .done   (done),
        .mdo    (mdio_o),
        .oe     (mdio_oe),
        .result (result)
    );

    a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [63:0] cap_bits;
    logic [63:0] cap_oe;
    int          rise_cnt = 0;
    realtime     t_r1, t_r2;
    logic [15:0] phy_val = '0;

    always #2.5 clk = ~clk;

    mdio_master dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // bus monitor: record the pin state at every MDC rising edge
    initial begin
        forever begin
            @(posedge mdc);
            cap_bits = {cap_bits[62:0], mdio_o};
            cap_oe   = {cap_oe[62:0], mdio_oe};
            rise_cnt++;
            if (rise_cnt == 1) t_r1 = $realtime;
            if (rise_cnt == 2) t_r2 = $realtime;
        end
    end

    // PHY model: present the read data for rising edges 49..64
    initial begin
        forever begin
            @(negedge mdc);
            if (rise_cnt + 1 >= 49 && rise_cnt + 1 <= 64)
                mdio_i = phy_val[15 - (rise_cnt + 1 - 49)];
            else
                mdio_i = 1'b1;
        end
    end

    task automatic wait_idle(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, s);
            if (s[0] == 1'b0) begin ok = 1; break; end
        end
    endtask

    task automatic run_frame(input int d, input logic [31:0] cmd,
                             input logic [15:0] pv, input bit first,
                             input bit inject);
        logic [31:0] s;
        bit          ok;
        bit          is_rd;
        logic [63:0] exp_oe;
        real         per;
        is_rd   = (cmd[29:28] == 2'b10);
        phy_val = pv;
        cap_bits = '0; cap_oe = '0; rise_cnt = 0;
        wr(2'd0, cmd);
        rd(2'd3, s);
        chk(s[0] == 1'b1, "R7 busy after accept", {63'd0, s[0]}, 64'd1);
        if (inject) begin
            repeat (40) @(negedge clk);
            wr(2'd0, ~cmd);
        end
        wait_idle(ok);
        chk(ok, "R7 busy clears at frame end", {63'd0, ok}, 64'd1);
        repeat (3) @(negedge clk);
        chk(rise_cnt == 64, "R1 rising edge count", 64'(rise_cnt), 64'd64);
        if (is_rd)
            chk(cap_bits[63:18] == {32'hFFFF_FFFF, cmd[31:18]},
                "R1 R2 read header bits", {18'd0, cap_bits[63:18]},
                {18'd0, 32'hFFFF_FFFF, cmd[31:18]});
        else
            chk(cap_bits == {32'hFFFF_FFFF, cmd}, "R1 R2 write frame bits",
                cap_bits, {32'hFFFF_FFFF, cmd});
        exp_oe = is_rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
        chk(cap_oe == exp_oe, "R3 output enable profile", cap_oe, exp_oe);
        per = t_r2 - t_r1;
        chk(per > 10.0 * d - 0.1 && per < 10.0 * d + 0.1, "R4 MDC period",
            64'(int'(per * 10)), 64'(100 * d));
        rd(2'd0, s);
        if (is_rd)
            chk(s == {16'd0, pv}, "R5 read data capture", {32'd0, s}, {48'd0, pv});
        else
            chk(s == {16'd0, cmd[15:0]}, "R5 write data readback",
                {32'd0, s}, {48'd0, cmd[15:0]});
        rd(2'd1, s);
        chk(s == 32'd1, "R6 event set at end", {32'd0, s}, 64'd1);
        if (first) begin
            wr(2'd1, 32'd0);
            rd(2'd1, s);
            chk(s == 32'd1, "R6 write 0 keeps event", {32'd0, s}, 64'd1);
        end
        wr(2'd1, 32'd1);
        rd(2'd1, s);
        chk(s == 32'd0, "R6 write 1 clears event", {32'd0, s}, 64'd0);
        if (inject) begin
            repeat (300) @(negedge clk);
            rd(2'd3, s);
            chk(s[0] == 1'b0 && rise_cnt == 64, "R7 command while busy ignored",
                64'(rise_cnt), 64'd64);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 pins after reset",
            {62'd0, mdc, mdio_oe}, 64'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), s);
            chk(s == 32'd0, "R10 register after reset", {32'd0, s}, 64'd0);
        end

        // R8: zero divider blocks a frame
        wr(2'd0, 32'h6000_0000);
        repeat (200) @(negedge clk);
        rd(2'd3, s);
        chk(s[0] == 1'b0 && rise_cnt == 0, "R8 zero divider starts nothing",
            64'(rise_cnt), 64'd0);
        rd(2'd1, s);
        chk(s == 32'd0, "R8 no event with zero divider", {32'd0, s}, 64'd0);

        for (int d = 1; d <= 4; d++) begin
            wr(2'd2, 32'(d) << 1);
            rd(2'd2, s);
            chk(s == (32'(d) << 1), "R4 divider readback", {32'd0, s},
                {32'd0, 32'(d) << 1});
            for (int k = 0; k < 4; k++) begin
                logic [1:0]  op;
                logic [4:0]  pa, ra;
                logic [15:0] dat, pv;
                logic [31:0] cmd;
                op  = k[0] ? 2'b10 : 2'b01;
                pa  = 5'((d * 7 + k * 5) & 31);
                ra  = 5'((k * 11 + d * 3) & 31);
                dat = 16'hA5C3 ^ 16'(d << 8) ^ 16'(k * 16'h1111);
                pv  = 16'h3C96 ^ 16'(d * 16'h0F01) ^ 16'(k << 4);
                cmd = {2'b01, op, pa, ra, 2'b10, dat};
                run_frame(d, cmd, pv, (d == 1 && k == 0), (d == 2 && k == 1));
            end
        end
        finish_run();
    end

endmodule